// File: doc/BRIEF.md
# Scan-Configured Routing Switch Box

This block is the routing switch box that sits where four routing channels meet in a programmable fabric. Each of the four sides (left, right, top, bottom) carries a 4-bit incoming track bus and a 4-bit outgoing track bus. Every outgoing track bit is a small multiplexer that picks one of three fixed tracks from the other three sides. The assignment of tracks is deliberately twisted, so a signal can change track number as it turns a corner. Track 3 on the left and right sides has a fourth choice: a single-bit output of the neighbouring logic block.

The sixteen 2-bit select fields live in one 32-bit serial configuration register. It shifts on the rising edge of `scan_clk` while `scan_en` is high, and it holds otherwise. Its last stage is brought out on `scan_out`, so the box can be placed in one configuration chain with its neighbours. Routing from track inputs to track outputs is purely combinational. There is no data stream with flow control; all pins are plain signals.

Top module: `sbox_switch`

## Requirements
- R1: While `rst_n` is low, the configuration register is all zeros: every output takes its select-0 source and `scan_out` is 0.
- R2: Field order: 16 fields of 2 bits, one per output; output k is left bits 0..3 (k=0..3), right 0..3 (k=4..7), top 0..3 (k=8..11), bottom 0..3 (k=12..15). The fields are shifted in starting with k=15 and ending with k=0, and each field is sent low bit first, so 32 enabled rising `scan_clk` edges load a complete configuration.
- R3: With `scan_en` low, `scan_clk` edges and `scan_in` leave the configuration and `scan_out` unchanged.
- R4: `scan_out` gives the register's last stage: while shifting, it presents bits in the order in which they were shifted in, 32 enabled edges after they entered.
- R5: Left outputs for selects 0/1/2: bit0 bottom[2]/top[1]/right[0]; bit1 bottom[1]/top[2]/right[1]; bit2 bottom[0]/top[3]/right[2]; bit3 bottom[3]/top[0]/right[3].
- R6: Right outputs for selects 0/1/2: bit0 bottom[3]/top[2]/left[0]; bit1 bottom[0]/top[1]/left[1]; bit2 bottom[1]/top[0]/left[2]; bit3 bottom[2]/top[3]/left[3].
- R7: Top outputs for selects 0/1/2: bit0 bottom[0]/right[2]/left[3]; bit1 bottom[1]/right[1]/left[0]; bit2 bottom[2]/right[0]/left[1]; bit3 bottom[3]/right[3]/left[2].
- R8: Bottom outputs for selects 0/1/2: bit0 top[0]/right[1]/left[2]; bit1 top[1]/right[2]/left[1]; bit2 top[2]/right[3]/left[0]; bit3 top[3]/right[0]/left[3].
- R9: Select 3 on left bit 3 drives `left_clb_in`; select 3 on right bit 3 drives `right_clb_in`.
- R10: Select 3 on any other output drives 0.
- R11: Routing is combinational: a change on any track or logic-block input reaches the selected outputs without a `scan_clk` edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scan_clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low clear of the configuration |
| scan_en | input | 1 | Shift enable |
| scan_in | input | 1 | Serial configuration input |
| scan_out | output | 1 | Last stage of the configuration register |
| left_in | input | 4 | Tracks arriving from the left channel |
| right_in | input | 4 | Tracks arriving from the right channel |
| top_in | input | 4 | Tracks arriving from the top channel |
| bottom_in | input | 4 | Tracks arriving from the bottom channel |
| left_clb_in | input | 1 | Logic-block output offered to left track 3 |
| right_clb_in | input | 1 | Logic-block output offered to right track 3 |
| left_out | output | 4 | Tracks driven into the left channel |
| right_out | output | 4 | Tracks driven into the right channel |
| top_out | output | 4 | Tracks driven into the top channel |
| bottom_out | output | 4 | Tracks driven into the bottom channel |

## Verification
A new configuration takes effect right after the rising `scan_clk` edge that captures its 32nd bit, and `scan_out` moves on every enabled edge. Track and logic-block inputs reach the outputs in zero cycles. The bench therefore changes inputs on the falling edge, samples a couple of nanoseconds later within the same low phase, and reads `scan_out` just before each shifting edge. The route checks compare every output nibble with a model computed from the stored selects and the current inputs.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int TRACKS  = 4;
  localparam int SIDES   = 4;
  localparam int SEL_W   = 2;
  localparam int NUM_OUT = SIDES * TRACKS;
  localparam int CFG_W   = NUM_OUT * SEL_W;
  localparam int SRC_LCLB = NUM_OUT;
  localparam int SRC_RCLB = NUM_OUT + 1;
  localparam int SRC_ZERO = NUM_OUT + 2;
  localparam int POOL_W   = NUM_OUT + 3;

  typedef enum int {SIDE_L = 0, SIDE_R = 1, SIDE_T = 2, SIDE_B = 3} side_e;

  // Pool index of the source for (side, track, select). Track indices in
  // the pool: left 0..3, right 4..7, top 8..11, bottom 12..15.
  function automatic int route_src(int side, int trk, int sel);
    int t0, t1, t2;
    t0 = SRC_ZERO; t1 = SRC_ZERO; t2 = SRC_ZERO;
    case (side * TRACKS + trk)
      0:  begin t0 = 14; t1 = 9;  t2 = 4; end
      1:  begin t0 = 13; t1 = 10; t2 = 5; end
      2:  begin t0 = 12; t1 = 11; t2 = 6; end
      3:  begin t0 = 15; t1 = 8;  t2 = 7; end
      4:  begin t0 = 15; t1 = 10; t2 = 0; end
      5:  begin t0 = 12; t1 = 9;  t2 = 1; end
      6:  begin t0 = 13; t1 = 8;  t2 = 2; end
      7:  begin t0 = 14; t1 = 11; t2 = 3; end
      8:  begin t0 = 12; t1 = 6;  t2 = 3; end
      9:  begin t0 = 13; t1 = 5;  t2 = 0; end
      10: begin t0 = 14; t1 = 4;  t2 = 1; end
      11: begin t0 = 15; t1 = 7;  t2 = 2; end
      12: begin t0 = 8;  t1 = 5;  t2 = 2; end
      13: begin t0 = 9;  t1 = 6;  t2 = 1; end
      14: begin t0 = 10; t1 = 7;  t2 = 0; end
      15: begin t0 = 11; t1 = 4;  t2 = 3; end
      default: ;
    endcase
    case (sel)
      0: return t0;
      1: return t1;
      2: return t2;
      default: begin
        if (side == SIDE_L && trk == TRACKS - 1) return SRC_LCLB;
        if (side == SIDE_R && trk == TRACKS - 1) return SRC_RCLB;
        return SRC_ZERO;
      end
    endcase
  endfunction
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q,
  output logic         dout
);
  // New bits enter at the top and walk toward bit 0, which leaves the chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= {din, q[W-1:1]};
  end

  assign dout = q[0];
endmodule

// File: rtl/sbox_mux.sv
module sbox_mux #(
  parameter int SEL_W = 2,
  localparam int N = 1 << SEL_W
) (
  input  logic [N-1:0]     cand,
  input  logic [SEL_W-1:0] sel,
  output logic             y
);
  assign y = cand[sel];
endmodule

// File: rtl/sbox_switch.sv
module sbox_switch
  import sbox_pkg::*;
(
  input  logic              scan_clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic [TRACKS-1:0] left_in,
  input  logic [TRACKS-1:0] right_in,
  input  logic [TRACKS-1:0] top_in,
  input  logic [TRACKS-1:0] bottom_in,
  input  logic              left_clb_in,
  input  logic              right_clb_in,
  output logic [TRACKS-1:0] left_out,
  output logic [TRACKS-1:0] right_out,
  output logic [TRACKS-1:0] top_out,
  output logic [TRACKS-1:0] bottom_out
);
  localparam int NCAND = 1 << SEL_W;

  logic [CFG_W-1:0]   cfg_q;
  logic [POOL_W-1:0]  pool;
  logic [NUM_OUT-1:0] out_flat;

  sbox_cfg_chain #(.W(CFG_W)) u_chain (
    .clk  (scan_clk),
    .rst_n(rst_n),
    .en   (scan_en),
    .din  (scan_in),
    .q    (cfg_q),
    .dout (scan_out)
  );

  assign pool = {1'b0, right_clb_in, left_clb_in, bottom_in, top_in, right_in, left_in};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    for (genvar b = 0; b < TRACKS; b++) begin : g_trk
      localparam int K = s * TRACKS + b;
      logic [NCAND-1:0] cand;
      for (genvar c = 0; c < NCAND; c++) begin : g_cand
        assign cand[c] = pool[route_src(s, b, c)];
      end
      sbox_mux #(.SEL_W(SEL_W)) u_mux (
        .cand(cand),
        .sel (cfg_q[SEL_W*(NUM_OUT-1-K) +: SEL_W]),
        .y   (out_flat[K])
      );
    end
  end

  assign left_out   = out_flat[0*TRACKS +: TRACKS];
  assign right_out  = out_flat[1*TRACKS +: TRACKS];
  assign top_out    = out_flat[2*TRACKS +: TRACKS];
  assign bottom_out = out_flat[3*TRACKS +: TRACKS];
endmodule

// File: rtl/sbox_switch_chk.sv
module sbox_switch_chk (
  input logic        scan_clk,
  input logic        rst_n,
  input logic        scan_en,
  input logic        scan_in,
  input logic        scan_out,
  input logic [31:0] cfg,
  input logic        left_clb_in,
  input logic        right_clb_in,
  input logic [3:0]  left_out,
  input logic [3:0]  right_out,
  input logic [3:0]  top_out,
  input logic [3:0]  bottom_out
);
  // R2: an enabled edge places scan_in at the top of the register
  a_r2_shift_entry: assert property (@(posedge scan_clk) disable iff (!rst_n)
    scan_en |=> (cfg[31] == $past(scan_in)) && (cfg[30:0] == $past(cfg[31:1])));

  // R3: no enable, no change
  a_r3_hold: assert property (@(posedge scan_clk) disable iff (!rst_n)
    !scan_en |=> $stable(cfg) && $stable(scan_out));

  // R4: scan_out follows the stage just above the last one after a shift
  a_r4_scan_out: assert property (@(posedge scan_clk) disable iff (!rst_n)
    scan_en |=> scan_out == $past(cfg[1]));

  // R9: select 3 on left/right track 3 passes the logic-block inputs
  a_r9_left_clb: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (cfg[25:24] == 2'b11) |-> left_out[3] == left_clb_in);
  a_r9_right_clb: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (cfg[17:16] == 2'b11) |-> right_out[3] == right_clb_in);

  // R10: select 3 elsewhere gives 0
  a_r10_top0_zero: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (cfg[15:14] == 2'b11) |-> !top_out[0]);
  a_r10_bot3_zero: assert property (@(posedge scan_clk) disable iff (!rst_n)
    (cfg[1:0] == 2'b11) |-> !bottom_out[3]);
endmodule

bind sbox_switch sbox_switch_chk u_chk (
  .scan_clk    (scan_clk),
  .rst_n       (rst_n),
  .scan_en     (scan_en),
  .scan_in     (scan_in),
  .scan_out    (scan_out),
  .cfg         (cfg_q),
  .left_clb_in (left_clb_in),
  .right_clb_in(right_clb_in),
  .left_out    (left_out),
  .right_out   (right_out),
  .top_out     (top_out),
  .bottom_out  (bottom_out)
);

// File: tb/tb_sbox_switch.sv
`timescale 1ns/1ps
module tb_sbox_switch;
  logic clk = 1'b0;
  logic rst_n, scan_en, scan_in, scan_out;
  logic [3:0] li, ri, ti, bi;
  logic lc, rc;
  logic [3:0] lo, ro, to, bo;

  int errors = 0;
  int checks = 0;
  logic [1:0] sel_q [16];
  logic       seq_a [32];

  always #10 clk = ~clk;

  sbox_switch dut (
    .scan_clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .left_in(li), .right_in(ri), .top_in(ti),
    .bottom_in(bi), .left_clb_in(lc), .right_clb_in(rc), .left_out(lo),
    .right_out(ro), .top_out(to), .bottom_out(bo));

  function automatic logic model(int side, int trk, logic [1:0] s);
    logic [3:0] c;
    case (side * 4 + trk)
      0:  c = {1'b0, ri[0], ti[1], bi[2]};
      1:  c = {1'b0, ri[1], ti[2], bi[1]};
      2:  c = {1'b0, ri[2], ti[3], bi[0]};
      3:  c = {lc,   ri[3], ti[0], bi[3]};
      4:  c = {1'b0, li[0], ti[2], bi[3]};
      5:  c = {1'b0, li[1], ti[1], bi[0]};
      6:  c = {1'b0, li[2], ti[0], bi[1]};
      7:  c = {rc,   li[3], ti[3], bi[2]};
      8:  c = {1'b0, li[3], ri[2], bi[0]};
      9:  c = {1'b0, li[0], ri[1], bi[1]};
      10: c = {1'b0, li[1], ri[0], bi[2]};
      11: c = {1'b0, li[2], ri[3], bi[3]};
      12: c = {1'b0, li[2], ri[1], ti[0]};
      13: c = {1'b0, li[1], ri[2], ti[1]};
      14: c = {1'b0, li[0], ri[3], ti[2]};
      default: c = {1'b0, li[3], ri[0], ti[3]};
    endcase
    return c[s];
  endfunction

  function automatic logic [3:0] side_exp(int side);
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = model(side, b, sel_q[side*4+b]);
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_routes();
    chk("R5 left",   {28'd0, lo}, {28'd0, side_exp(0)});
    chk("R6 right",  {28'd0, ro}, {28'd0, side_exp(1)});
    chk("R7 top",    {28'd0, to}, {28'd0, side_exp(2)});
    chk("R8 bottom", {28'd0, bo}, {28'd0, side_exp(3)});
  endtask

  task automatic drive_inputs();
    @(negedge clk);
    {li, ri, ti, bi} = 16'($urandom);
    {lc, rc} = 2'($urandom);
    #2;
  endtask

  task automatic push(logic b);
    @(negedge clk);
    scan_en = 1'b1;
    scan_in = b;
  endtask

  // R2: fields from k=15 down to k=0, each low bit first
  task automatic load_cfg();
    for (int k = 15; k >= 0; k--) begin
      push(sel_q[k][0]);
      push(sel_q[k][1]);
    end
    @(negedge clk);
    scan_en = 1'b0;
    #2;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; scan_en = 1'b0; scan_in = 1'b0;
    li = 4'h5; ri = 4'hA; ti = 4'h3; bi = 4'hC; lc = 1'b1; rc = 1'b1;
    for (int k = 0; k < 16; k++) sel_q[k] = 2'd0;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    chk("R1 scan_out", {31'd0, scan_out}, 32'd0);
    check_routes();
    rst_n = 1'b1;

    // R9/R10: all selects 3
    for (int k = 0; k < 16; k++) sel_q[k] = 2'd3;
    load_cfg();
    for (int i = 0; i < 4; i++) begin
      drive_inputs();
      chk("R9 left clb",  {31'd0, lo[3]}, {31'd0, lc});
      chk("R9 right clb", {31'd0, ro[3]}, {31'd0, rc});
      chk("R10 zeros", {16'd0, bo, to, 1'b0, ro[2:0], 1'b0, lo[2:0]}, 32'd0);
    end
    // R11: toggle clb inputs between edges
    @(negedge clk);
    lc = ~lc; rc = ~rc;
    #1;
    chk("R11 comb clb", {30'd0, ro[3], lo[3]}, {30'd0, rc, lc});

    // R2: single field directed checks
    for (int k = 0; k < 16; k++) sel_q[k] = 2'd0;
    sel_q[0] = 2'd2; sel_q[15] = 2'd1;
    load_cfg();
    drive_inputs();
    chk("R2 first field", {31'd0, lo[0]}, {31'd0, ri[0]});
    chk("R2 last field",  {31'd0, bo[3]}, {31'd0, ri[0]});
    check_routes();

    // random configurations
    for (int it = 0; it < 30; it++) begin
      for (int k = 0; k < 16; k++) sel_q[k] = 2'($urandom);
      load_cfg();
      for (int p = 0; p < 3; p++) begin
        drive_inputs();
        check_routes();
      end
      // R11: change tracks without a clock edge
      @(negedge clk);
      {li, ri, ti, bi} = ~{li, ri, ti, bi};
      #1;
      chk("R11 comb left", {28'd0, lo}, {28'd0, side_exp(0)});
    end

    // R3: toggling scan_in with scan_en low
    begin
      logic so_before;
      so_before = scan_out;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        scan_in = 1'($urandom);
      end
      #2;
      chk("R3 scan_out hold", {31'd0, scan_out}, {31'd0, so_before});
      check_routes();
    end

    // R4: shift out pattern A while loading B
    for (int k = 0; k < 16; k++) sel_q[k] = 2'($urandom);
    for (int k = 15; k >= 0; k--) begin
      seq_a[2*(15-k)]   = sel_q[k][0];
      seq_a[2*(15-k)+1] = sel_q[k][1];
    end
    load_cfg();
    begin
      int bad;
      logic [1:0] nb [16];
      bad = 0;
      for (int k = 0; k < 16; k++) nb[k] = 2'($urandom);
      for (int i = 0; i < 32; i++) begin
        push(nb[15 - i/2][i%2]);
        #1;
        if (scan_out !== seq_a[i]) bad++;
      end
      @(negedge clk);
      scan_en = 1'b0;
      #2;
      chk("R4 scan_out sequence", bad, 0);
      for (int k = 0; k < 16; k++) sel_q[k] = nb[k];
      check_routes();
    end

    // R1: reset mid-run returns to select 0
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    for (int k = 0; k < 16; k++) sel_q[k] = 2'd0;
    chk("R1 reset again", {31'd0, scan_out}, 32'd0);
    check_routes();
    rst_n = 1'b1;

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule